// File: doc/BRIEF.md
# Interleaved Vector Load/Store Instruction Decoder

This block sits in the decode stage of a vector unit. It looks at one 32-bit instruction word per cycle and decides whether the word belongs to the family of interleaving stores and deinterleaving loads. In that family, a transfer moves one 16-byte slice between memory and either two or four consecutive vector registers. For a member of the family, the block extracts the operand fields and judges whether the encoding is legal. For a legal encoding with base update, it also supplies the amount to add to the base register.

The result is a registered decode bundle, ready one cycle after the word is presented. A word outside the family is reported as such, with no undefined flag, so that other decoders can claim it. This block does not perform the memory beats, the register-bank check or the feature-enable check.

Top module: `ilv_decode`

## Requirements
- R1: A word is a family member (`dec_hit`=1) only when all of these hold: bits 31:23 equal 111111001, bit 12 is 1, bits 11:9 equal 111, and bits 4:1 are 0. For any other word, `dec_hit` and `dec_undef` are both 0.
- R2: The fields are decoded as follows:
  - direction: bit 20, where 1 means load;
  - base update: bit 21;
  - base register: bits 19:16;
  - destination index: bit 22 concatenated above bits 15:13;
  - element size: bits 8:7;
  - pattern: bits 6:5;
  - four-way mode: bit 0, where 0 means two-way.
- R3: An element-size code of 3 makes a family member undefined.
- R4: In two-way mode, pattern values 2 and 3 are undefined. In four-way mode, all four pattern values are legal.
- R5: The destination index is undefined above 6 in two-way mode and above 4 in four-way mode. The limit values themselves are legal.
- R6: Base register 15 is always undefined. Base register 13 is undefined only when base update is set.
- R7: `dec_inc` is 32 in two-way mode and 64 in four-way mode, for a legal family member with base update set. In every other case it is 0.
- R8: All outputs register a word presented with `insn_vld`=1 and appear at the next clock edge. `dec_vld` mirrors the previous cycle's `insn_vld`.
- R9: While `rst_n` is low at a clock edge, every output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_vld | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| dec_vld | output | 1 | Decode bundle refers to a word presented last cycle |
| dec_hit | output | 1 | Word belongs to the interleaved transfer family |
| dec_undef | output | 1 | Family member with an illegal encoding |
| dec_load | output | 1 | 1 for load, 0 for store |
| dec_four | output | 1 | 1 for four-way, 0 for two-way |
| dec_wb | output | 1 | Base update requested |
| dec_base | output | 4 | Base register number |
| dec_dst | output | 4 | First destination register index |
| dec_esize | output | 2 | Element size code |
| dec_pat | output | 2 | Pattern number |
| dec_inc | output | 7 | Base increment, 0 when no update applies |

## Verification
Every result of this block comes from a single register stage. The bench therefore drives a word on a falling edge, lets one rising edge capture it, and reads every output at the following falling edge. The hit flag, the undefined flag, the fields and the increment are all due at that same point, and `dec_vld` falls one edge after `insn_vld` is withdrawn. Each directed case compares the whole bundle against values that the bench derives from the requirements, so a cycle of extra or missing latency shows up as a mismatch.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved load/store decoder.
// Assumes a 4-bit general register number and a 4-bit vector index.
package ilv_pkg;

    localparam int GPR_W  = 4;
    localparam int VIDX_W = 4;

    // Decoded operand fields of one family word.
    typedef struct packed {
        logic              is_load;
        logic              four_way;
        logic              wb;
        logic [GPR_W-1:0]  base;
        logic [VIDX_W-1:0] dst;
        logic [1:0]        esize;
        logic [1:0]        pat;
    } ilv_fields_t;

endpackage

// File: rtl/ilv_field_extract.sv
// Field extractor: matches the fixed opcode bits and slices out the operands.
// Purely combinational; assumes a 32-bit little-endian-numbered word.
module ilv_field_extract
    import ilv_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output logic              hit,
    output ilv_fields_t       flds
);

    localparam logic [8:0] TOP_OPC = 9'b111111001;

    // Opcode match over the fixed bit groups.
    always_comb begin
        hit = (insn[31:23] == TOP_OPC) && insn[12] &&
              (insn[11:9] == 3'b111) && (insn[4:1] == 4'b0000);
    end

    // Operand slicing.
    always_comb begin
        flds.is_load  = insn[20];
        flds.wb       = insn[21];
        flds.base     = insn[19:16];
        flds.dst      = {insn[22], insn[15:13]};
        flds.esize    = insn[8:7];
        flds.pat      = insn[6:5];
        flds.four_way = insn[0];
    end

endmodule

// File: rtl/ilv_legality.sv
// Legality checker: flags the encodings of a family word that are undefined.
// Assumes hit qualification happens outside; judges the fields only.
module ilv_legality
    import ilv_pkg::*;
#(
    parameter int LIM_TWO  = 6,
    parameter int LIM_FOUR = 4,
    parameter int PC_REG   = 15,
    parameter int SP_REG   = 13
) (
    input  ilv_fields_t flds,
    output logic        bad
);

    localparam logic [VIDX_W-1:0] L2  = VIDX_W'(LIM_TWO);
    localparam logic [VIDX_W-1:0] L4  = VIDX_W'(LIM_FOUR);
    localparam logic [GPR_W-1:0]  RPC = GPR_W'(PC_REG);
    localparam logic [GPR_W-1:0]  RSP = GPR_W'(SP_REG);

    logic size_bad, pat_bad, dst_bad, base_bad;

    // Per-rule checks.
    always_comb begin
        size_bad = (flds.esize == 2'd3);
        pat_bad  = !flds.four_way && flds.pat[1];
        dst_bad  = flds.four_way ? (flds.dst > L4) : (flds.dst > L2);
        base_bad = (flds.base == RPC) || ((flds.base == RSP) && flds.wb);
    end

    // Combine the rules.
    always_comb bad = size_bad | pat_bad | dst_bad | base_bad;

endmodule

// File: rtl/ilv_stride.sv
// Stride unit: picks the base-register increment for a legal update.
// Assumes the caller gates with hit and legality through `ok`.
module ilv_stride
    import ilv_pkg::*;
#(
    parameter int INC_TWO  = 32,
    parameter int INC_FOUR = 64,
    parameter int INC_W    = 7
) (
    input  ilv_fields_t      flds,
    input  logic             ok,
    output logic [INC_W-1:0] inc
);

    localparam logic [INC_W-1:0] S2 = INC_W'(INC_TWO);
    localparam logic [INC_W-1:0] S4 = INC_W'(INC_FOUR);

    // Select by mode, zero when no update applies.
    always_comb begin
        if (ok && flds.wb) inc = flds.four_way ? S4 : S2;
        else               inc = '0;
    end

endmodule

// File: rtl/ilv_decode.sv
// Top of the interleaved load/store decoder: extract, judge, register.
// One-cycle latency; fields hold their last captured value when idle.
module ilv_decode
    import ilv_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int LIM_TWO  = 6,
    parameter int LIM_FOUR = 4,
    parameter int INC_TWO  = 32,
    parameter int INC_FOUR = 64,
    parameter int INC_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_vld,
    input  logic [INSN_W-1:0] insn,
    output logic              dec_vld,
    output logic              dec_hit,
    output logic              dec_undef,
    output logic              dec_load,
    output logic              dec_four,
    output logic              dec_wb,
    output logic [3:0]        dec_base,
    output logic [3:0]        dec_dst,
    output logic [1:0]        dec_esize,
    output logic [1:0]        dec_pat,
    output logic [INC_W-1:0]  dec_inc
);

    logic             hit_c, bad_c, ok_c;
    ilv_fields_t      flds_c;
    logic [INC_W-1:0] inc_c;

    ilv_field_extract #(.INSN_W(INSN_W)) u_ext (
        .insn (insn),
        .hit  (hit_c),
        .flds (flds_c)
    );

    ilv_legality #(.LIM_TWO(LIM_TWO), .LIM_FOUR(LIM_FOUR)) u_leg (
        .flds (flds_c),
        .bad  (bad_c)
    );

    // Legal family member.
    always_comb ok_c = hit_c && !bad_c;

    ilv_stride #(.INC_TWO(INC_TWO), .INC_FOUR(INC_FOUR), .INC_W(INC_W)) u_str (
        .flds (flds_c),
        .ok   (ok_c),
        .inc  (inc_c)
    );

    // Valid flag tracks the input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dec_vld <= 1'b0;
        else        dec_vld <= insn_vld;
    end

    // Decode bundle captured on a presented word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_hit   <= 1'b0;
            dec_undef <= 1'b0;
            dec_load  <= 1'b0;
            dec_four  <= 1'b0;
            dec_wb    <= 1'b0;
            dec_base  <= '0;
            dec_dst   <= '0;
            dec_esize <= '0;
            dec_pat   <= '0;
            dec_inc   <= '0;
        end else if (insn_vld) begin
            dec_hit   <= hit_c;
            dec_undef <= hit_c && bad_c;
            dec_load  <= flds_c.is_load;
            dec_four  <= flds_c.four_way;
            dec_wb    <= flds_c.wb;
            dec_base  <= flds_c.base;
            dec_dst   <= flds_c.dst;
            dec_esize <= flds_c.esize;
            dec_pat   <= flds_c.pat;
            dec_inc   <= inc_c;
        end
    end

endmodule

// File: rtl/ilv_decode_chk.sv
// Checker for ilv_decode: temporal and cross-output properties.
// Assumes synchronous active-low reset; bound to every ilv_decode instance.
module ilv_decode_chk #(
    parameter int INC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_vld,
    input logic [31:0]      insn,
    input logic             dec_vld,
    input logic             dec_hit,
    input logic             dec_undef,
    input logic             dec_four,
    input logic             dec_wb,
    input logic [3:0]       dec_base,
    input logic [1:0]       dec_esize,
    input logic [1:0]       dec_pat,
    input logic [INC_W-1:0] dec_inc
);

    a_r1_undef_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        dec_undef |-> dec_hit);

    a_r2_base_captured: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld |=> (dec_base == $past(insn[19:16])));

    a_r3_size3_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_esize == 2'd3) |-> dec_undef);

    a_r4_two_way_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && !dec_four && dec_pat[1]) |-> dec_undef);

    a_r6_pc_base_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_base == 4'd15) |-> dec_undef);

    a_r7_inc_only_legal_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_inc != '0) |-> (dec_hit && !dec_undef && dec_wb));

    a_r8_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
        insn_vld |=> dec_vld);

    a_r8_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |=> !dec_vld);

endmodule

bind ilv_decode ilv_decode_chk #(.INC_W(INC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_vld  (insn_vld),
    .insn      (insn),
    .dec_vld   (dec_vld),
    .dec_hit   (dec_hit),
    .dec_undef (dec_undef),
    .dec_four  (dec_four),
    .dec_wb    (dec_wb),
    .dec_base  (dec_base),
    .dec_esize (dec_esize),
    .dec_pat   (dec_pat),
    .dec_inc   (dec_inc)
);

// File: tb/ilv_decode_tb.sv
module ilv_decode_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_vld = 1'b0;
    logic [31:0] insn = '0;
    logic        dec_vld, dec_hit, dec_undef, dec_load, dec_four, dec_wb;
    logic [3:0]  dec_base, dec_dst;
    logic [1:0]  dec_esize, dec_pat;
    logic [6:0]  dec_inc;

    int checks = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_decode u_dut (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn),
        .dec_vld(dec_vld), .dec_hit(dec_hit), .dec_undef(dec_undef),
        .dec_load(dec_load), .dec_four(dec_four), .dec_wb(dec_wb),
        .dec_base(dec_base), .dec_dst(dec_dst), .dec_esize(dec_esize),
        .dec_pat(dec_pat), .dec_inc(dec_inc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Word builder following the field positions in R1 and R2.
    function automatic logic [31:0] mk(input logic ld, input logic four, input logic wb,
                                       input logic [3:0] rn, input logic [3:0] dst,
                                       input logic [1:0] sz, input logic [1:0] pt);
        logic [31:0] w;
        w = '0;
        w[31:23] = 9'b111111001;
        w[22] = dst[3]; w[21] = wb; w[20] = ld; w[19:16] = rn;
        w[15:13] = dst[2:0]; w[12] = 1'b1; w[11:9] = 3'b111;
        w[8:7] = sz; w[6:5] = pt; w[0] = four;
        return w;
    endfunction

    // Drive one word on a falling edge, read the bundle one rising edge later.
    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        insn = w; insn_vld = 1'b1;
        @(negedge clk);
        insn_vld = 1'b0;
    endtask

    // Family-member case: expected values computed from R2..R7.
    task automatic fam_case(input string req, input logic ld, input logic four, input logic wb,
                            input logic [3:0] rn, input logic [3:0] dst,
                            input logic [1:0] sz, input logic [1:0] pt);
        logic und; int inc;
        und = (sz == 2'd3) || (!four && pt >= 2) ||
              (four ? (dst > 4) : (dst > 6)) ||
              (rn == 4'd15) || (rn == 4'd13 && wb);
        inc = (!und && wb) ? (four ? 64 : 32) : 0;
        apply(mk(ld, four, wb, rn, dst, sz, pt));
        chk(req, "vld",   dec_vld,   1);
        chk(req, "hit",   dec_hit,   1);
        chk(req, "undef", dec_undef, und);
        chk(req, "load",  dec_load,  ld);
        chk(req, "four",  dec_four,  four);
        chk(req, "wb",    dec_wb,    wb);
        chk(req, "base",  dec_base,  rn);
        chk(req, "dst",   dec_dst,   dst);
        chk(req, "esize", dec_esize, sz);
        chk(req, "pat",   dec_pat,   pt);
        chk(req, "inc",   dec_inc,   inc);
    endtask

    task automatic t_reset;   // R9
        chk("R9", "vld",   dec_vld,   0);
        chk("R9", "hit",   dec_hit,   0);
        chk("R9", "undef", dec_undef, 0);
        chk("R9", "base",  dec_base,  0);
        chk("R9", "inc",   dec_inc,   0);
    endtask

    task automatic t_fields;  // R2
        fam_case("R2", 1, 0, 0, 4'd3,  4'd5, 2'd1, 2'd1);
        fam_case("R2", 0, 1, 0, 4'd10, 4'd2, 2'd2, 2'd3);
        fam_case("R2", 1, 1, 1, 4'd0,  4'd0, 2'd0, 2'd0);
    endtask

    task automatic t_size;    // R3
        fam_case("R3", 1, 0, 0, 4'd2, 4'd0, 2'd3, 2'd0);
        fam_case("R3", 0, 1, 1, 4'd2, 4'd0, 2'd3, 2'd1);
    endtask

    task automatic t_pattern; // R4
        fam_case("R4", 1, 0, 0, 4'd1, 4'd1, 2'd0, 2'd2);
        fam_case("R4", 1, 0, 0, 4'd1, 4'd1, 2'd1, 2'd3);
        fam_case("R4", 0, 1, 0, 4'd1, 4'd1, 2'd1, 2'd2);
        fam_case("R4", 0, 1, 0, 4'd1, 4'd1, 2'd0, 2'd3);
    endtask

    task automatic t_dst;     // R5
        fam_case("R5", 1, 0, 0, 4'd4, 4'd6, 2'd0, 2'd0);
        fam_case("R5", 1, 0, 0, 4'd4, 4'd7, 2'd0, 2'd0);
        fam_case("R5", 1, 1, 0, 4'd4, 4'd4, 2'd0, 2'd0);
        fam_case("R5", 1, 1, 0, 4'd4, 4'd5, 2'd0, 2'd0);
        fam_case("R5", 1, 0, 0, 4'd4, 4'd8, 2'd0, 2'd0);
    endtask

    task automatic t_base;    // R6
        fam_case("R6", 1, 0, 0, 4'd15, 4'd0, 2'd0, 2'd0);
        fam_case("R6", 1, 0, 1, 4'd13, 4'd0, 2'd0, 2'd0);
        fam_case("R6", 1, 0, 0, 4'd13, 4'd0, 2'd0, 2'd0);
    endtask

    task automatic t_inc;     // R7
        fam_case("R7", 0, 0, 1, 4'd5, 4'd2, 2'd1, 2'd1);
        fam_case("R7", 0, 1, 1, 4'd5, 4'd2, 2'd2, 2'd2);
        fam_case("R7", 0, 1, 0, 4'd5, 4'd2, 2'd2, 2'd2);
        fam_case("R7", 0, 1, 1, 4'd5, 4'd6, 2'd2, 2'd2);
    endtask

    task automatic t_nomatch; // R1
        logic [31:0] base_w;
        base_w = mk(1, 0, 1, 4'd2, 4'd1, 2'd0, 2'd0);
        apply(base_w ^ 32'h0000_1000);
        chk("R1", "hit bit12",   dec_hit,   0);
        chk("R1", "undef bit12", dec_undef, 0);
        apply(base_w ^ 32'h0000_0004);
        chk("R1", "hit bit2",    dec_hit,   0);
        apply(mk(1, 0, 1, 4'd15, 4'd1, 2'd3, 2'd3) ^ 32'h0100_0000);
        chk("R1", "hit top",     dec_hit,   0);
        chk("R1", "undef top",   dec_undef, 0);
        chk("R1", "inc top",     dec_inc,   0);
        apply(base_w);
        chk("R1", "hit match",   dec_hit,   1);
    endtask

    task automatic t_latency; // R8
        @(negedge clk);
        insn = mk(1, 1, 1, 4'd7, 4'd3, 2'd1, 2'd0); insn_vld = 1'b1;
        chk("R8", "inc before edge", dec_inc, 32);
        @(negedge clk);
        insn_vld = 1'b0;
        chk("R8", "vld after edge", dec_vld, 1);
        chk("R8", "inc after edge", dec_inc, 64);
        insn = mk(0, 0, 0, 4'd1, 4'd1, 2'd0, 2'd0);
        @(negedge clk);
        chk("R8", "vld dropped", dec_vld, 0);
        chk("R8", "base held",   dec_base, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fields();
        t_size();
        t_pattern();
        t_dst();
        t_base();
        t_inc();
        t_nomatch();
        t_latency();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule